// File: doc/BRIEF.md
# Four-Way Set-Associative Word Cache

This block sits between a 32-bit byte-addressed requester and a simple word-wide memory port. It keeps four ways that share one set index. Each way acts as its own direct-mapped array of 256 one-word lines. Every lookup compares the address tag against the four lines of the selected set in the same cycle. A hit returns the stored word at once, together with the number of the matching way.

A read that misses sends one memory read and holds off the requester until the word comes back. The word is then written into the way named by an external replacement unit and handed to the requester. Writes always go through to memory. A write that hits also updates the enabled byte lanes of the cached line. A write that misses leaves the cache contents alone.

The requester holds `reqValid` and its request fields steady until it sees `reqDone`.

Top module: `setAssocCache`

## Requirements
- R1: The cache has four ways of 256 lines each, and all four ways share one set index. Address bits [9:2] select the set and bits [31:10] form the 22-bit tag, so the same tag in a different set does not hit.
- R2: A request hits when a valid line in the selected set holds the address tag. On a read hit, `reqHit`, `reqHitWay` and `reqRdata` are all valid in that same cycle, with `reqDone`=1.
- R3: Address bits [1:0] have no effect on the lookup. Any byte address inside a cached word hits that word.
- R4: Reset clears every valid bit. While reset is asserted, `reqDone`, `reqHit` and `memReqValid` are 0, and the first access to any word after reset misses.
- R5: A read miss behaves as follows:
  - In the lookup cycle it raises `memReqValid` for exactly one cycle, with `memReqWrite`=0 and `memReqAddr` equal to the request address with bits [1:0] forced to 0.
  - `reqDone` stays 0 until `memRspValid` arrives.
  - In the cycle `memRspValid` is 1, `reqDone`=1 and `reqRdata`=`memRspRdata`.
- R6: On the read-miss response, the word, tag and valid=1 are written into the way named by `victimWay` in that cycle, replacing whatever that way held for the set.
- R7: A write completes in its first cycle (`reqDone`=1). In that same cycle it drives `memReqValid`=1 and `memReqWrite`=1, with the word address, `reqWdata` and `reqBe` on the memory port.
- R8: A write hit updates only the byte lanes of the matching line whose enable is set. `reqBe` bit i covers data bits [8i+7:8i].
- R9: A write miss does not allocate a line, so a later read of that address still misses.
- R10: At most one way matches at any time. `reqHitWay` gives that way, and it is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until reqDone |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte-lane enables for writes |
| victimWay | input | 2 | Way to fill on a read miss, from the replacement unit |
| reqDone | output | 1 | Request completes this cycle |
| reqHit | output | 1 | Lookup hit |
| reqHitWay | output | 2 | Matching way, 0 on miss |
| reqRdata | output | 32 | Read data |
| memReqValid | output | 1 | Memory request strobe |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | 32 | Word-aligned memory address |
| memReqWdata | output | 32 | Memory write data |
| memReqBe | output | 4 | Memory write byte enables |
| memRspValid | input | 1 | Read response strobe |
| memRspRdata | input | 32 | Read response data |

## Verification
Four different tags are filled into one set through all four victim choices, and then all four are read back. This separates true four-way placement from any scheme that lets one way overwrite another. Further patterns probe the address split: a fifth tag forces an eviction, the same tag is read in a neighbouring set, and a byte offset inside a cached word is used. Each of these shows whether the tag, index and offset fields are split at the right bits. The write patterns cover a hit with a sparse byte-enable mask and a miss followed by a read of the same address; these tell lane merging apart from whole-word writes, and no-allocate apart from write-allocate. Memory latencies of one to three cycles, plus a reset in the middle of the run, show whether the stall and the valid clearing depend on timing.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NUM_WAYS = 4;
  localparam int NUM_SETS = 256;

  typedef struct packed {
    logic fill;   // write victim line from memory response
    logic wrHit;  // merge write data into matching line
  } ctrlStrobe_t;
endpackage

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cache_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int WAYS = NUM_WAYS,
  parameter int SETS = NUM_SETS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [DW/8-1:0]          be,
  input  logic [$clog2(WAYS)-1:0]  victimWay,
  input  logic [DW-1:0]            fillData,
  input  ctrlStrobe_t              strobe,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hitWay,
  output logic [DW-1:0]            rdata,
  output logic [WAYS-1:0]          matchVec
);
  localparam int OFF_W = $clog2(DW/8);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int LANES = DW / 8;

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] addrTag;
  logic [DW-1:0]    wayData [WAYS];

  assign setIdx  = addr[OFF_W +: IDX_W];
  assign addrTag = addr[AW-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tagMem  [SETS];
    logic [DW-1:0]    dataMem [SETS];
    logic [SETS-1:0]  validQ;
    logic             isVictim;

    assign isVictim    = (victimWay == WAY_W'(w));
    assign matchVec[w] = validQ[setIdx] && (tagMem[setIdx] == addrTag);
    assign wayData[w]  = dataMem[setIdx];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= '0;
      else if (strobe.fill && isVictim) validQ[setIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (strobe.fill && isVictim) begin
        tagMem[setIdx]  <= addrTag;
        dataMem[setIdx] <= fillData;
      end else if (strobe.wrHit && matchVec[w]) begin
        for (int b = 0; b < LANES; b++)
          if (be[b]) dataMem[setIdx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    hit    = |matchVec;
    hitWay = '0;
    rdata  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (matchVec[w]) begin
        hitWay = hitWay | WAY_W'(w);
        rdata  = rdata | wayData[w];
      end
    end
  end
endmodule

// File: rtl/cacheCtrl.sv
module cacheCtrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        hit,
  input  logic        memRspValid,
  output ctrlStrobe_t strobe,
  output logic        reqDone,
  output logic        useMemData,
  output logic        memReqValid,
  output logic        memReqWrite
);
  typedef enum logic {ST_LOOKUP, ST_WAIT} ctrlState_t;
  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOOKUP;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqDone     = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    useMemData  = (stateQ == ST_WAIT);
    case (stateQ)
      ST_LOOKUP: begin
        if (reqValid) begin
          if (reqWrite) begin
            memReqValid  = 1'b1;
            memReqWrite  = 1'b1;
            reqDone      = 1'b1;
            strobe.wrHit = hit;
          end else if (hit) begin
            reqDone = 1'b1;
          end else begin
            memReqValid = 1'b1;
            stateD      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.fill = 1'b1;
          reqDone     = 1'b1;
          stateD      = ST_LOOKUP;
        end
      end
      default: stateD = ST_LOOKUP;
    endcase
  end
endmodule

// File: rtl/setAssocCache.sv
module setAssocCache
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [3:0]  reqBe,
  input  logic [1:0]  victimWay,
  output logic        reqDone,
  output logic        reqHit,
  output logic [1:0]  reqHitWay,
  output logic [31:0] reqRdata,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic [31:0] memReqAddr,
  output logic [31:0] memReqWdata,
  output logic [3:0]  memReqBe,
  input  logic        memRspValid,
  input  logic [31:0] memRspRdata
);
  ctrlStrobe_t strobe;
  logic        useMemData;
  logic [31:0] arrayRdata;
  logic [3:0]  matchVec;

  cacheDatapath u_data (
    .clk(clk), .rstN(rstN), .addr(reqAddr), .wdata(reqWdata), .be(reqBe),
    .victimWay(victimWay), .fillData(memRspRdata), .strobe(strobe),
    .hit(reqHit), .hitWay(reqHitWay), .rdata(arrayRdata), .matchVec(matchVec)
  );

  cacheCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .hit(reqHit), .memRspValid(memRspValid), .strobe(strobe),
    .reqDone(reqDone), .useMemData(useMemData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite)
  );

  assign reqRdata    = useMemData ? memRspRdata : arrayRdata;
  assign memReqAddr  = {reqAddr[31:2], 2'b00};
  assign memReqWdata = reqWdata;
  assign memReqBe    = reqBe;
endmodule

// File: rtl/setAssocCache_chk.sv
module setAssocCache_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        reqDone,
  input logic        reqHit,
  input logic [1:0]  reqHitWay,
  input logic [31:0] reqRdata,
  input logic        memReqValid,
  input logic        memReqWrite,
  input logic        memRspValid,
  input logic [31:0] memRspRdata,
  input logic [3:0]  matchVec
);
  p_one_match_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));
  p_way_zero_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqHit |-> reqHitWay == 2'd0);
  p_read_hit_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && reqHit |-> reqDone);
  p_miss_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite |=> !memReqValid);
  p_miss_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite |-> !reqDone);
  p_rsp_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqDone && !reqHit && !reqWrite |-> reqRdata == memRspRdata);
  p_write_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> reqDone);
endmodule

bind setAssocCache setAssocCache_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqDone(reqDone), .reqHit(reqHit), .reqHitWay(reqHitWay), .reqRdata(reqRdata),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memRspValid(memRspValid), .memRspRdata(memRspRdata), .matchVec(matchVec)
);

// File: tb/setAssocCache_tb.sv
`timescale 1ns/1ps
module setAssocCache_tb;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0;
  logic [3:0] reqBe = 0;
  logic [1:0] victimWay = 0;
  logic reqDone, reqHit, memReqValid, memReqWrite;
  logic [1:0] reqHitWay;
  logic [31:0] reqRdata, memReqAddr, memReqWdata;
  logic [3:0] memReqBe;
  logic memRspValid = 0;
  logic [31:0] memRspRdata = 0;

  always #10 clk = ~clk;

  setAssocCache u_dut (.*);

  int tests = 0, fails = 0;
  bit mValid [4][256];
  int unsigned mTag [4][256];
  logic [31:0] mData [4][256];
  logic [31:0] memStore [int unsigned];
  bit waiting = 0;
  int memCnt = 0, latency = 1;
  bit lastDone = 0;

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memStore.exists(a)) return memStore[a];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] b);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (b[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mk(input int unsigned tag, input int unsigned idx,
                                     input int unsigned off);
    return (tag << 10) | (idx << 2) | off;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle, entered at a falling edge with the request inputs already set
  task automatic step();
    int unsigned idx, tag;
    bit eHit, eDone, eMq, eMw;
    int eWay;
    logic [31:0] eData, wa;
    memRspValid = waiting && (memCnt == 0);
    memRspRdata = memRspValid ? memRead({reqAddr[31:2], 2'b00}) : 32'h0;
    #2;
    idx = reqAddr[9:2]; tag = reqAddr[31:10]; wa = {reqAddr[31:2], 2'b00};
    eHit = 0; eWay = 0; eData = 0; eDone = 0; eMq = 0; eMw = 0;
    for (int w = 0; w < 4; w++)
      if (mValid[w][idx] && mTag[w][idx] == tag) begin eHit = 1; eWay = w; eData = mData[w][idx]; end
    if (waiting) begin
      if (memRspValid) begin eDone = 1; eData = memRspRdata; end
    end else if (reqValid) begin
      if (reqWrite) begin eMq = 1; eMw = 1; eDone = 1; end
      else if (eHit) eDone = 1;
      else eMq = 1;
    end
    chk("R2", "hit", reqHit, eHit);
    chk("R10", "hitWay", reqHitWay, eWay);
    chk("R5", "done", reqDone, eDone);
    chk(eMw ? "R7" : "R5", "memReqValid", memReqValid, eMq);
    if (eMq) begin
      chk(eMw ? "R7" : "R5", "memReqWrite", memReqWrite, eMw);
      chk(eMw ? "R7" : "R5", "memReqAddr", memReqAddr, wa);
      if (eMw) begin
        chk("R7", "memReqWdata", memReqWdata, reqWdata);
        chk("R7", "memReqBe", memReqBe, reqBe);
      end
    end
    if (eDone && !reqWrite) chk(waiting ? "R5" : "R2", "rdata", reqRdata, eData);
    // model update for the coming edge
    if (!waiting && reqValid && reqWrite) begin
      memStore[wa] = merge(memRead(wa), reqWdata, reqBe);
      if (eHit) mData[eWay][idx] = merge(mData[eWay][idx], reqWdata, reqBe); // R8
    end else if (!waiting && reqValid && !eHit) begin
      waiting = 1; memCnt = latency - 1;
    end else if (waiting && memRspValid) begin
      mValid[victimWay][idx] = 1; mTag[victimWay][idx] = tag;     // R6
      mData[victimWay][idx] = memRspRdata; waiting = 0;
    end else if (waiting) memCnt--;
    lastDone = reqDone;
    @(negedge clk);
    memRspValid = 0;
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] b, input logic [1:0] v, input int lat);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = b;
    victimWay = v; latency = lat; lastDone = 0;
    for (int i = 0; i < 20 && !lastDone; i++) step();
    if (!lastDone) chk("R5", "request never completed", 0, 1);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic doReset();
    reqValid = 0; rstN = 0;
    #2;
    chk("R4", "done in reset", reqDone, 0);
    chk("R4", "hit in reset", reqHit, 0);
    chk("R4", "memReqValid in reset", memReqValid, 0);
    for (int w = 0; w < 4; w++) for (int s = 0; s < 256; s++) mValid[w][s] = 0;
    waiting = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();                                       // R4
    access(0, mk(1, 5, 0), 0, 0, 2'd0, 2);           // R4 R5 first access misses
    access(0, mk(1, 5, 0), 0, 0, 2'd3, 1);           // R2 hit in way 0
    access(0, mk(1, 5, 3), 0, 0, 2'd3, 1);           // R3 offset ignored
    access(0, mk(2, 5, 0), 0, 0, 2'd1, 1);           // R1 R6 fill way 1
    access(0, mk(3, 5, 1), 0, 0, 2'd2, 3);           // R6 fill way 2
    access(0, mk(4, 5, 0), 0, 0, 2'd3, 1);           // R6 fill way 3
    for (int t = 1; t <= 4; t++) access(0, mk(t, 5, 2), 0, 0, 2'd0, 1); // R1 R10
    access(0, mk(5, 5, 0), 0, 0, 2'd2, 2);           // R6 evicts tag 3
    access(0, mk(3, 5, 0), 0, 0, 2'd0, 1);           // R6 miss again, evicts tag 1
    access(0, mk(1, 6, 0), 0, 0, 2'd1, 1);           // R1 same tag, other set
    access(1, mk(2, 5, 0), 32'hA1B2C3D4, 4'b0101, 2'd0, 1); // R7 R8
    access(0, mk(2, 5, 0), 0, 0, 2'd0, 1);           // R8 merged lanes
    access(1, mk(9, 7, 2), 32'h11223344, 4'b1110, 2'd0, 1); // R7 R9
    access(0, mk(9, 7, 0), 0, 0, 2'd3, 2);           // R9 still misses
    access(0, mk(9, 7, 0), 0, 0, 2'd0, 1);           // R2 now hits way 3
    for (int i = 0; i < 3; i++) step();              // idle
    doReset();                                       // R4 mid-run reset
    access(0, mk(2, 5, 0), 0, 0, 2'd1, 1);           // R4 misses after reset
    access(0, mk(2, 5, 0), 0, 0, 2'd2, 1);           // R2
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule